// File: doc/BRIEF.md
# Synchronized Precision Time Counter

This block keeps a free-running time-of-day value for packet timestamping. The main timer holds three 32-bit words: whole seconds-scale high word, a nanosecond low word and a sub-nanosecond fraction. A second, port-side timer mirrors the lower 64 bits (nanoseconds and fraction). Each timer adds its own 40-bit increment on every cycle in which `tick` is high. The increment has an 8-bit whole-nanosecond part above a 32-bit fraction.

Software never writes a running timer directly. It stages values in shadow registers and arms a command code for each timer through a simple word-wide register bus. A single `sync_strobe` then applies both armed commands on the same clock edge. This keeps the two timers aligned. The commands are load time, load increment, signed nanosecond adjust and snapshot read.

Top module: `tod_sync_timer`

## Requirements
- R1: After reset both timers and all snapshot words are zero and both increments equal `INC_RESET` (default 1 ns per tick, 40'h01_0000_0000).
- R2: In a cycle with `tick` high and no time-changing command applied, each timer adds its zero-extended 40-bit increment; with the default increment, N ticks add N to the nanosecond word.
- R3: A strobe with command code 1 (load time) loads the main timer with {high, low, fraction} shadows and the port timer with {port nanosecond shadow, 32'h0}. The new value shows on `tod_now`/`port_now` in the cycle after the strobe edge.
- R4: Code 2 (load increment) loads the increment from {adjust-high[7:0], adjust-low}. The timer does not advance on the edge that applies it, even with `tick` high; later ticks use the new increment.
- R5: Code 3 (adjust) adds the sign-extended 64-bit value {adjust-high, adjust-low} to the timer. The adjust-high word is a two's-complement nanosecond offset. The adjust supersedes a coinciding tick.
- R6: Code 4 (snapshot) copies the timer value present before the strobe edge into the snapshot words, while the timer keeps ticking on that edge.
- R7: Codes 0, 5, 6 and 7 change neither time nor snapshots. Every strobe returns both armed command fields to 0, so a repeated strobe without re-arming has no effect.
- R8: The port control word keeps the command in bits [2:0] and free bits in [31:3]. A strobe clears only bits [2:0]. The free bits are read back unchanged, so software can read-modify-write the command.
- R9: Writing shadows or command fields without a strobe leaves both timers unchanged.
- R10: A read with `bus_rd` high returns the addressed word on `bus_rdata` one cycle later. Addresses: 0/1/2 main shadow fraction/low/high, 3/4 main adjust low/high, 5 main command, 8 port nanosecond shadow, 9/10 port adjust low/high, 11 port control, 16/17/18 main snapshot fraction/low/high, 20/21 port snapshot fraction/nanoseconds; other addresses read 0.
- R11: A carry out of the main low word increments the high word, while the port timer wraps at 64 bits.
- R12: Each timer applies only its own armed command, so an adjust armed for the main timer alone leaves the port timer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write enable |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Registered read data |
| sync_strobe | input | 1 | Applies both armed commands on this edge |
| tick | input | 1 | Advance enable for both timers |
| tod_now | output | 3*WORD_W | Main time {high, low, fraction} |
| port_now | output | 2*WORD_W | Port time {nanoseconds, fraction} |

## Verification
The bench drives the low word to just below its wrap and ticks across the wrap. A design that loses the carry would leave the high word stuck while the port timer correctly wraps to a small value. A negative adjust that borrows across the word boundary catches zero-extension of the offset, which would add about four billion nanoseconds instead. Strobes with `tick` high show whether the load-increment edge leaks an extra tick and whether a snapshot wrongly freezes the timer. A main-only adjust, a repeated unarmed strobe and the reserved code show that commands stay separate per timer and are cleared after use.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int CMD_W  = 3;
  localparam int ADDR_W = 5;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE      = 3'd0,
    CMD_LOAD_TIME = 3'd1,
    CMD_LOAD_INC  = 3'd2,
    CMD_ADJUST    = 3'd3,
    CMD_SNAPSHOT  = 3'd4,
    CMD_ADJ_AT    = 3'd5
  } tod_cmd_e;

  localparam logic [ADDR_W-1:0] A_MSHD_FRAC = 5'd0;
  localparam logic [ADDR_W-1:0] A_MSHD_LO   = 5'd1;
  localparam logic [ADDR_W-1:0] A_MSHD_HI   = 5'd2;
  localparam logic [ADDR_W-1:0] A_MADJ_LO   = 5'd3;
  localparam logic [ADDR_W-1:0] A_MADJ_HI   = 5'd4;
  localparam logic [ADDR_W-1:0] A_MCMD      = 5'd5;
  localparam logic [ADDR_W-1:0] A_PSHD_NS   = 5'd8;
  localparam logic [ADDR_W-1:0] A_PADJ_LO   = 5'd9;
  localparam logic [ADDR_W-1:0] A_PADJ_HI   = 5'd10;
  localparam logic [ADDR_W-1:0] A_PCTRL     = 5'd11;
  localparam logic [ADDR_W-1:0] A_MSNAP_FR  = 5'd16;
  localparam logic [ADDR_W-1:0] A_MSNAP_LO  = 5'd17;
  localparam logic [ADDR_W-1:0] A_MSNAP_HI  = 5'd18;
  localparam logic [ADDR_W-1:0] A_PSNAP_FR  = 5'd20;
  localparam logic [ADDR_W-1:0] A_PSNAP_NS  = 5'd21;
endpackage

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int TW = 96,
  parameter int INC_W = 40,
  parameter int ADJ_W = 64,
  parameter logic [INC_W-1:0] INC_RESET = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          apply,
  input  tod_cmd_e      cmd,
  input  logic [TW-1:0] shd_time,
  input  logic [ADJ_W-1:0] shd_adj,
  output logic [TW-1:0] time_q,
  output logic [TW-1:0] snap_q
);
  logic [INC_W-1:0] inc_q;
  logic [TW-1:0]    adj_ext;
  logic [TW-1:0]    inc_ext;
  logic [TW-1:0]    ticked;

  always_comb begin
    adj_ext = TW'($signed(shd_adj));
    inc_ext = TW'(inc_q);
    ticked  = time_q + inc_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q <= '0;
      snap_q <= '0;
      inc_q  <= INC_RESET;
    end else begin
      if (tick) time_q <= ticked;
      if (apply) begin
        unique case (cmd)
          CMD_LOAD_TIME: time_q <= shd_time;
          CMD_LOAD_INC: begin
            inc_q  <= shd_adj[INC_W-1:0];
            time_q <= time_q;
          end
          CMD_ADJUST:   time_q <= time_q + adj_ext;
          CMD_SNAPSHOT: snap_q <= time_q;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic                sync_strobe,
  input  logic [3*WORD_W-1:0] main_snap,
  input  logic [2*WORD_W-1:0] port_snap,
  output logic [3*WORD_W-1:0] main_shd_time,
  output logic [2*WORD_W-1:0] main_adj,
  output tod_cmd_e            main_cmd,
  output logic [2*WORD_W-1:0] port_shd_time,
  output logic [2*WORD_W-1:0] port_adj,
  output tod_cmd_e            port_cmd
);
  logic [WORD_W-1:0] mshd_fr_q, mshd_lo_q, mshd_hi_q;
  logic [WORD_W-1:0] madj_lo_q, madj_hi_q;
  logic [WORD_W-1:0] pshd_ns_q, padj_lo_q, padj_hi_q;
  logic [WORD_W-1:0] pctrl_q;
  logic [CMD_W-1:0]  mcmd_q;
  logic [WORD_W-1:0] rd_mux;

  assign main_shd_time = {mshd_hi_q, mshd_lo_q, mshd_fr_q};
  assign main_adj      = {madj_hi_q, madj_lo_q};
  assign port_shd_time = {pshd_ns_q, {WORD_W{1'b0}}};
  assign port_adj      = {padj_hi_q, padj_lo_q};
  assign main_cmd      = tod_cmd_e'(mcmd_q);
  assign port_cmd      = tod_cmd_e'(pctrl_q[CMD_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      mshd_fr_q <= '0; mshd_lo_q <= '0; mshd_hi_q <= '0;
      madj_lo_q <= '0; madj_hi_q <= '0;
      pshd_ns_q <= '0; padj_lo_q <= '0; padj_hi_q <= '0;
      pctrl_q   <= '0;
      mcmd_q    <= '0;
    end else begin
      if (sync_strobe) begin
        mcmd_q <= '0;
        pctrl_q[CMD_W-1:0] <= '0;
      end
      if (bus_wr) begin
        case (bus_addr)
          A_MSHD_FRAC: mshd_fr_q <= bus_wdata;
          A_MSHD_LO:   mshd_lo_q <= bus_wdata;
          A_MSHD_HI:   mshd_hi_q <= bus_wdata;
          A_MADJ_LO:   madj_lo_q <= bus_wdata;
          A_MADJ_HI:   madj_hi_q <= bus_wdata;
          A_MCMD:      mcmd_q    <= bus_wdata[CMD_W-1:0];
          A_PSHD_NS:   pshd_ns_q <= bus_wdata;
          A_PADJ_LO:   padj_lo_q <= bus_wdata;
          A_PADJ_HI:   padj_hi_q <= bus_wdata;
          A_PCTRL:     pctrl_q   <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_MSHD_FRAC: rd_mux = mshd_fr_q;
      A_MSHD_LO:   rd_mux = mshd_lo_q;
      A_MSHD_HI:   rd_mux = mshd_hi_q;
      A_MADJ_LO:   rd_mux = madj_lo_q;
      A_MADJ_HI:   rd_mux = madj_hi_q;
      A_MCMD:      rd_mux = WORD_W'(mcmd_q);
      A_PSHD_NS:   rd_mux = pshd_ns_q;
      A_PADJ_LO:   rd_mux = padj_lo_q;
      A_PADJ_HI:   rd_mux = padj_hi_q;
      A_PCTRL:     rd_mux = pctrl_q;
      A_MSNAP_FR:  rd_mux = main_snap[WORD_W-1:0];
      A_MSNAP_LO:  rd_mux = main_snap[2*WORD_W-1:WORD_W];
      A_MSNAP_HI:  rd_mux = main_snap[3*WORD_W-1:2*WORD_W];
      A_PSNAP_FR:  rd_mux = port_snap[WORD_W-1:0];
      A_PSNAP_NS:  rd_mux = port_snap[2*WORD_W-1:WORD_W];
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/tod_sync_timer.sv
module tod_sync_timer
  import tod_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int INC_INT_W = 8,
  parameter logic [INC_INT_W+WORD_W-1:0] INC_RESET = {INC_INT_W'(1), WORD_W'(0)}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic                sync_strobe,
  input  logic                tick,
  output logic [3*WORD_W-1:0] tod_now,
  output logic [2*WORD_W-1:0] port_now
);
  localparam int INC_W  = INC_INT_W + WORD_W;
  localparam int MAIN_W = 3 * WORD_W;
  localparam int PORT_W = 2 * WORD_W;
  localparam int ADJ_W  = 2 * WORD_W;

  logic [MAIN_W-1:0] main_shd_w, main_snap_w;
  logic [PORT_W-1:0] port_shd_w, port_snap_w;
  logic [ADJ_W-1:0]  main_adj_w, port_adj_w;
  tod_cmd_e          main_cmd_w, port_cmd_w;

  tod_regs #(.WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sync_strobe(sync_strobe),
    .main_snap(main_snap_w), .port_snap(port_snap_w),
    .main_shd_time(main_shd_w), .main_adj(main_adj_w), .main_cmd(main_cmd_w),
    .port_shd_time(port_shd_w), .port_adj(port_adj_w), .port_cmd(port_cmd_w)
  );

  tod_counter #(.TW(MAIN_W), .INC_W(INC_W), .ADJ_W(ADJ_W), .INC_RESET(INC_RESET)) u_main (
    .clk(clk), .rst(rst), .tick(tick), .apply(sync_strobe), .cmd(main_cmd_w),
    .shd_time(main_shd_w), .shd_adj(main_adj_w),
    .time_q(tod_now), .snap_q(main_snap_w)
  );

  tod_counter #(.TW(PORT_W), .INC_W(INC_W), .ADJ_W(ADJ_W), .INC_RESET(INC_RESET)) u_port (
    .clk(clk), .rst(rst), .tick(tick), .apply(sync_strobe), .cmd(port_cmd_w),
    .shd_time(port_shd_w), .shd_adj(port_adj_w),
    .time_q(port_now), .snap_q(port_snap_w)
  );
endmodule

// File: rtl/tod_sync_timer_chk.sv
module tod_sync_timer_chk
  import tod_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic                sync_strobe,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [CMD_W-1:0]    main_cmd,
  input logic [CMD_W-1:0]    port_cmd,
  input logic [3*WORD_W-1:0] main_shd,
  input logic [2*WORD_W-1:0] port_shd,
  input logic [3*WORD_W-1:0] tod_now,
  input logic [2*WORD_W-1:0] port_now,
  input logic [3*WORD_W-1:0] main_snap
);
  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!tick && !sync_strobe) |=> ($stable(tod_now) && $stable(port_now)));

  assert_main_load_R3: assert property (@(posedge clk) disable iff (rst)
    (sync_strobe && main_cmd == 3'd1) |=> (tod_now == $past(main_shd)));

  assert_port_load_R3: assert property (@(posedge clk) disable iff (rst)
    (sync_strobe && port_cmd == 3'd1) |=> (port_now == $past(port_shd)));

  assert_snapshot_R6: assert property (@(posedge clk) disable iff (rst)
    (sync_strobe && main_cmd == 3'd4) |=> (main_snap == $past(tod_now)));

  assert_cmd_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (sync_strobe && !(bus_wr && (bus_addr == A_MCMD || bus_addr == A_PCTRL)))
      |=> (main_cmd == 3'd0 && port_cmd == 3'd0));
endmodule

bind tod_sync_timer tod_sync_timer_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .sync_strobe(sync_strobe),
  .bus_wr(bus_wr), .bus_addr(bus_addr),
  .main_cmd(main_cmd_w), .port_cmd(port_cmd_w),
  .main_shd(main_shd_w), .port_shd(port_shd_w),
  .tod_now(tod_now), .port_now(port_now), .main_snap(main_snap_w)
);

// File: tb/tod_sync_timer_bench.sv
`timescale 1ns/1ps
module tod_sync_timer_bench;
  import tod_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, sync_strobe = 1'b0, tick = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [95:0] tod_now;
  logic [63:0] port_now;

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  localparam logic [31:0] SCRATCH = 32'hABCD_0000;

  always #2.5 clk = ~clk;

  tod_sync_timer u_tod_sync_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_strobe(sync_strobe),
    .tick(tick), .tod_now(tod_now), .port_now(port_now)
  );

  // scoreboard monitor: read data is valid one cycle after the request
  always @(posedge clk) rd_seen <= bus_rd && !rst;
  always @(negedge clk) begin
    if (rd_seen) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected read data act=%h exp=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s read act=%h exp=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic strobe(input logic with_tick);
    sync_strobe = 1'b1; tick = with_tick;
    @(posedge clk); #1;
    sync_strobe = 1'b0; tick = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick = 1'b0;
  endtask

  task automatic chk(input string t, input logic [95:0] em, input logic [63:0] ep);
    tests++;
    if (tod_now !== em || port_now !== ep) begin
      fails++;
      $display("FAIL %s main act=%h exp=%h port act=%h exp=%h", t, tod_now, em, port_now, ep);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk("R1 reset", 96'h0, 64'h0);
    rd(A_MSNAP_HI, 32'h0, "R1 snapshot reset");

    // R2 default increment, 10 ticks
    run_ticks(10);
    chk("R2 tick advance", {32'h0, 32'hA, 32'h0}, {32'hA, 32'h0});

    // R9 staging without strobe
    wr(A_MSHD_HI, 32'h1234);
    wr(A_MSHD_LO, 32'hFFFF_FFF0);
    wr(A_MSHD_FRAC, 32'h0);
    wr(A_PSHD_NS, 32'hFFFF_FFF0);
    wr(A_MCMD, 32'd1);
    wr(A_PCTRL, SCRATCH | 32'd1);
    chk("R9 staged no effect", {32'h0, 32'hA, 32'h0}, {32'hA, 32'h0});
    rd(A_PCTRL, SCRATCH | 32'd1, "R8 control readback");

    // R3 load time
    strobe(1'b0);
    chk("R3 load time", {32'h1234, 32'hFFFF_FFF0, 32'h0}, {32'hFFFF_FFF0, 32'h0});
    rd(A_MCMD, 32'h0, "R7 main command cleared");
    rd(A_PCTRL, SCRATCH, "R8 free bits kept");
    rd(A_MSHD_HI, 32'h1234, "R10 shadow readback");

    // R11 carry into high word, port wraps
    run_ticks(20);
    chk("R11 carry", {32'h1235, 32'h4, 32'h0}, {32'h4, 32'h0});

    // R4 load increment 2.5 ns, tick superseded on the applying edge
    wr(A_MADJ_LO, 32'h8000_0000);
    wr(A_MADJ_HI, 32'h2);
    wr(A_PADJ_LO, 32'h8000_0000);
    wr(A_PADJ_HI, 32'h2);
    wr(A_MCMD, 32'd2);
    wr(A_PCTRL, SCRATCH | 32'd2);
    strobe(1'b1);
    chk("R4 no tick on load", {32'h1235, 32'h4, 32'h0}, {32'h4, 32'h0});
    run_ticks(4);
    chk("R4 new increment", {32'h1235, 32'hE, 32'h0}, {32'hE, 32'h0});

    // R5 negative adjust with borrow
    wr(A_MADJ_LO, 32'h0);
    wr(A_MADJ_HI, 32'hFFFF_FFEC);
    wr(A_PADJ_LO, 32'h0);
    wr(A_PADJ_HI, 32'hFFFF_FFEC);
    wr(A_MCMD, 32'd3);
    wr(A_PCTRL, SCRATCH | 32'd3);
    strobe(1'b1);
    chk("R5 negative adjust", {32'h1234, 32'hFFFF_FFFA, 32'h0}, {32'hFFFF_FFFA, 32'h0});

    // R12 main-only positive adjust
    wr(A_MADJ_HI, 32'h10);
    wr(A_MCMD, 32'd3);
    strobe(1'b0);
    chk("R12 main only adjust", {32'h1235, 32'hA, 32'h0}, {32'hFFFF_FFFA, 32'h0});

    // R6 snapshot with tick
    wr(A_MCMD, 32'd4);
    wr(A_PCTRL, SCRATCH | 32'd4);
    strobe(1'b1);
    chk("R6 keeps ticking", {32'h1235, 32'hC, 32'h8000_0000}, {32'hFFFF_FFFC, 32'h8000_0000});
    rd(A_MSNAP_FR, 32'h0, "R6 main snap fraction");
    rd(A_MSNAP_LO, 32'hA, "R6 main snap low");
    rd(A_MSNAP_HI, 32'h1235, "R6 main snap high");
    rd(A_PSNAP_FR, 32'h0, "R6 port snap fraction");
    rd(A_PSNAP_NS, 32'hFFFF_FFFA, "R6 port snap ns");

    // R7 unarmed strobe and reserved code
    strobe(1'b0);
    chk("R7 unarmed strobe", {32'h1235, 32'hC, 32'h8000_0000}, {32'hFFFF_FFFC, 32'h8000_0000});
    wr(A_MCMD, 32'd5);
    wr(A_PCTRL, SCRATCH | 32'd7);
    strobe(1'b0);
    chk("R7 reserved code", {32'h1235, 32'hC, 32'h8000_0000}, {32'hFFFF_FFFC, 32'h8000_0000});
    rd(A_MSNAP_LO, 32'hA, "R7 snapshot untouched");
    rd(A_PCTRL, SCRATCH, "R8 free bits after strobe");
    rd(5'd31, 32'h0, "R10 unmapped address");

    repeat (3) @(posedge clk);
    #1;
    if (exp_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL R10 missing read data act=%0d exp=0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule